// File: doc/BRIEF.md
# Asynchronous Schedule Traversal Controller

This block decides when a USB host controller may walk its asynchronous list, the chain of control and bulk work that is served outside the periodic schedule. It has three states: idle (schedule not active), traversing (active) and backing off (sleeping). While traversing, it raises a request to the list walker. The request stays up until the microframe ends or until the walker reports that a whole pass found nothing to do.

An empty pass does not lead to an immediate re-poll. The controller sleeps for a programmable number of timebase ticks, which takes load off system memory, and then resumes traversal. Each time traversal starts, whether from idle or after a sleep, a sticky reclamation status bit is set. Software clears that bit by writing 1.

Descriptor fetch, transaction execution and the periodic schedule are outside this block. They reach it only as the single-cycle flags on its input ports.

Top module: `asy_trav_ctrl`

## Requirements
- R1: After reset, `trav_req` is 0 and `recl_stat` is 0, and the controller is idle.
- R2: When idle, traversal starts at the clock edge that samples `sof`=1 with `sched_en`=1 and `per_busy`=0. While `per_busy`=1 it stays idle.
- R3: While traversing, `trav_req` stays 1 on every cycle until an exit condition is sampled.
- R4: While traversing, `mf_end`=1 returns the controller to idle on the next edge. This applies even if `list_empty` is 1 in the same cycle, so no sleep is started.
- R5: While traversing, `list_empty`=1 with `mf_end`=0 moves the controller to sleep, and `trav_req` is 0 for the whole sleep.
- R6: On entering sleep, the timer is loaded with `SLEEP_TICKS` (default 10000, which is 10 ms of 1 µs ticks). It counts down only on cycles with `tick`=1. The tick that takes it from 1 to 0 returns the controller to traversing, so `trav_req` rises exactly after the `SLEEP_TICKS`-th tick.
- R7: Every entry into traversing, from idle or from sleep, sets `recl_stat` to 1.
- R8: `recl_stat` holds its value until a cycle with `recl_clr`=1 clears it. If a set event and `recl_clr` fall in the same cycle, the bit ends up 1.
- R9: `sched_en`=0 forces idle at the next edge from any state, drops `trav_req` and clears the sleep timer. A later sleep therefore always lasts the full `SLEEP_TICKS` ticks.
- R10: While sleeping, `sof`, `mf_end`, `list_empty` and `per_busy` have no effect. Only the timer expiry or `sched_en`=0 end the sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sched_en | input | 1 | Asynchronous schedule enable |
| per_busy | input | 1 | Periodic schedule currently active |
| sof | input | 1 | Start-of-microframe pulse |
| mf_end | input | 1 | End-of-microframe pulse |
| list_empty | input | 1 | Walker found an empty pass |
| tick | input | 1 | Timebase tick pulse for the sleep timer |
| recl_clr | input | 1 | Software write-1-to-clear of the reclamation bit |
| trav_req | output | 1 | Traverse request to the list walker |
| recl_stat | output | 1 | Sticky reclamation status bit |

## Verification
The assertions do not rely on any input being a clean one-cycle pulse or following a protocol. Each input may take any value on any cycle, so a stuck `mf_end` or a `list_empty` that arrives outside traversal must still leave the state machine legal. The only assumption is that inputs change away from the sampling edge. The stimulus respects this by changing every input on the falling clock edge. It biases `sched_en` high and `mf_end` low, so traversal runs for long stretches and the walk reaches sleeps that expire. It also drives random inputs during sleeps, to show that those inputs are ignored.

// File: rtl/asy_trav_pkg.sv
package asy_trav_pkg;
   typedef enum logic [1:0] {
      ST_OFF = 2'd0,
      ST_RUN = 2'd1,
      ST_NAP = 2'd2
   } asy_state_e;
endpackage

// File: rtl/asy_sleep_timer.sv
module asy_sleep_timer #(
   parameter int unsigned SLEEP_TICKS = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic load,
   input  logic dec_en,
   output logic expire,
   output logic busy
);
   localparam int unsigned CNT_W = (SLEEP_TICKS < 2) ? 1 : $clog2(SLEEP_TICKS + 1);

   if (SLEEP_TICKS < 1) begin : g_bad_len
      $error("asy_sleep_timer: SLEEP_TICKS must be at least 1");
   end

   if (SLEEP_TICKS == 1) begin : g_flag
      // single-tick back-off needs only an armed flag
      logic armed;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            armed <= 1'b0;
         else if (clr)          armed <= 1'b0;
         else if (load)         armed <= 1'b1;
         else if (dec_en)       armed <= 1'b0;
      end
      assign expire = dec_en && armed && !clr && !load;
      assign busy   = armed;
   end else begin : g_count
      localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SLEEP_TICKS);
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        cnt <= '0;
         else if (clr)                      cnt <= '0;
         else if (load)                     cnt <= LOAD_VAL;
         else if (dec_en && cnt != '0)      cnt <= cnt - 1'b1;
      end
      assign expire = dec_en && (cnt == CNT_W'(1)) && !clr && !load;
      assign busy   = (cnt != '0);

      // R6
      cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (dec_en && !clr && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
      // R6
      cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!dec_en && !clr && !load) |=> $stable(cnt));
      // R9
      cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         clr |=> (cnt == '0));
   end
endmodule

// File: rtl/asy_recl_flag.sv
module asy_recl_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag <= 1'b0;
      else if (set)  flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
   end

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag);
   // R8
   clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag);
   // R8
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !set) |=> $stable(flag));
endmodule

// File: rtl/asy_trav_fsm.sv
module asy_trav_fsm
   import asy_trav_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       per_busy,
   input  logic       sof,
   input  logic       mf_end,
   input  logic       list_empty,
   input  logic       tick,
   input  logic       expire,
   output asy_state_e state,
   output logic       tmr_load,
   output logic       tmr_clr,
   output logic       tmr_dec,
   output logic       recl_set
);
   asy_state_e state_nxt;

   always_comb begin
      state_nxt = state;
      tmr_load  = 1'b0;
      recl_set  = 1'b0;
      if (!en) begin
         state_nxt = ST_OFF;
      end else begin
         unique case (state)
            ST_OFF: if (sof && !per_busy) begin
               state_nxt = ST_RUN;
               recl_set  = 1'b1;
            end
            ST_RUN: if (mf_end) begin
               state_nxt = ST_OFF;
            end else if (list_empty) begin
               state_nxt = ST_NAP;
               tmr_load  = 1'b1;
            end
            ST_NAP: if (expire) begin
               state_nxt = ST_RUN;
               recl_set  = 1'b1;
            end
            default: state_nxt = ST_OFF;
         endcase
      end
   end

   assign tmr_clr = !en;
   assign tmr_dec = en && tick && (state == ST_NAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_OFF;
      else        state <= state_nxt;
   end

   // R9
   dis_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (state == ST_OFF));
   // R4
   eof_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && state == ST_RUN && mf_end) |=> (state == ST_OFF));
   // R2
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OFF && per_busy) |=> (state == ST_OFF));
   // R5
   empty_nap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && state == ST_RUN && list_empty && !mf_end) |=> (state == ST_NAP));
   // R10
   nap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && state == ST_NAP && !expire) |=> (state == ST_NAP));
   // R3
   run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && state == ST_RUN && !mf_end && !list_empty) |=> (state == ST_RUN));
endmodule

// File: rtl/asy_trav_ctrl.sv
module asy_trav_ctrl
   import asy_trav_pkg::*;
#(
   parameter int unsigned SLEEP_TICKS = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sched_en,
   input  logic per_busy,
   input  logic sof,
   input  logic mf_end,
   input  logic list_empty,
   input  logic tick,
   input  logic recl_clr,
   output logic trav_req,
   output logic recl_stat
);
   asy_state_e state;
   logic tmr_load, tmr_clr, tmr_dec, tmr_expire, tmr_busy, recl_set;

   asy_trav_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (sched_en),
      .per_busy   (per_busy),
      .sof        (sof),
      .mf_end     (mf_end),
      .list_empty (list_empty),
      .tick       (tick),
      .expire     (tmr_expire),
      .state      (state),
      .tmr_load   (tmr_load),
      .tmr_clr    (tmr_clr),
      .tmr_dec    (tmr_dec),
      .recl_set   (recl_set)
   );

   asy_sleep_timer #(.SLEEP_TICKS(SLEEP_TICKS)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (tmr_clr),
      .load   (tmr_load),
      .dec_en (tmr_dec),
      .expire (tmr_expire),
      .busy   (tmr_busy)
   );

   asy_recl_flag u_recl (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (recl_set),
      .clr   (recl_clr),
      .flag  (recl_stat)
   );

   assign trav_req = (state == ST_RUN);

   // R7
   entry_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trav_req) |-> recl_stat);
   // R5
   nap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_NAP) |-> (!trav_req && tmr_busy));
   // R9
   off_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sched_en |=> !trav_req);
endmodule

// File: tb/asy_trav_ctrl_bench.sv
`timescale 1ns/1ps
module asy_trav_ctrl_bench;
   localparam int SLP = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sched_en = 0, per_busy = 0, sof = 0, mf_end = 0, list_empty = 0, tick = 0, recl_clr = 0;
   logic trav_req, recl_stat;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 0;

   // model state: 0 idle, 1 traversing, 2 sleeping
   int  m_st = 0;
   int  m_cnt = 0;
   bit  m_recl = 0;

   always #10 clk = ~clk;

   asy_trav_ctrl #(.SLEEP_TICKS(SLP)) u_asy_trav_ctrl (
      .clk(clk), .rst_n(rst_n), .sched_en(sched_en), .per_busy(per_busy),
      .sof(sof), .mf_end(mf_end), .list_empty(list_empty), .tick(tick),
      .recl_clr(recl_clr), .trav_req(trav_req), .recl_stat(recl_stat)
   );

   function automatic int nxt_state(int st, int cnt, bit en, bit bz, bit so, bit eo, bit em, bit tk);
      if (!en) return 0;
      case (st)
         0: return (so && !bz) ? 1 : 0;
         1: return eo ? 0 : (em ? 2 : 1);
         default: return (tk && cnt == 1) ? 1 : 2;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_recl = 0;
      end else begin
         int ns;
         bit set;
         ns = nxt_state(m_st, m_cnt, sched_en, per_busy, sof, mf_end, list_empty, tick);
         set = (ns == 1) && (m_st != 1);
         if (!sched_en) m_cnt = 0;
         else if (m_st == 1 && ns == 2) m_cnt = SLP;
         else if (m_st == 2 && tick && m_cnt > 0) m_cnt = m_cnt - 1;
         m_st = ns;
         m_recl = set ? 1'b1 : (recl_clr ? 1'b0 : m_recl);
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_vec++;
         if (trav_req !== (m_st == 1)) begin
            n_bad++;
            $display("FAIL R3 model trav_req act=%0b exp=%0b", trav_req, m_st == 1);
         end
         if (recl_stat !== m_recl) begin
            n_bad++;
            $display("FAIL R8 model recl_stat act=%0b exp=%0b", recl_stat, m_recl);
         end
      end
   end

   task automatic chk(input bit act, input bit exp, input string tag);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
      end
   endtask

   task automatic pulse_tick(input int n);
      tick = 1;
      repeat (n) @(negedge clk);
      tick = 0;
   endtask

   task automatic pulse_sof();
      sof = 1; @(negedge clk); sof = 0;
   endtask

   task automatic pulse_empty();
      list_empty = 1; @(negedge clk); list_empty = 0;
   endtask

   initial begin
      #(200000 * 20);
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(trav_req, 0, "R1 req at reset");
      chk(recl_stat, 0, "R1 recl at reset");
      rst_n = 1;
      @(negedge clk);
      sched_en = 1;
      // R2 blocked while periodic busy
      per_busy = 1; pulse_sof(); per_busy = 0;
      chk(trav_req, 0, "R2 busy blocks start");
      pulse_sof();
      chk(trav_req, 1, "R2 start on sof");
      chk(recl_stat, 1, "R7 set on first entry");
      recl_clr = 1; @(negedge clk); recl_clr = 0;
      chk(recl_stat, 0, "R8 write-1 clears");
      repeat (3) @(negedge clk);
      chk(trav_req, 1, "R3 request held");
      // R5 empty -> sleep, R10 ignored inputs during sleep
      pulse_empty();
      chk(trav_req, 0, "R5 sleep drops request");
      sof = 1; mf_end = 1; list_empty = 1; per_busy = 1;
      @(negedge clk);
      sof = 0; mf_end = 0; list_empty = 0; per_busy = 0;
      chk(trav_req, 0, "R10 sleep ignores frame inputs");
      pulse_tick(SLP - 1);
      chk(trav_req, 0, "R6 still asleep before last tick");
      chk(recl_stat, 0, "R8 stays clear during sleep");
      repeat (2) @(negedge clk);
      chk(trav_req, 0, "R6 no decay without ticks");
      pulse_tick(1);
      chk(trav_req, 1, "R6 wake on final tick");
      chk(recl_stat, 1, "R7 set on wake");
      // R4 end of microframe wins over empty
      mf_end = 1; list_empty = 1; @(negedge clk); mf_end = 0; list_empty = 0;
      chk(trav_req, 0, "R4 eof exits");
      pulse_tick(SLP + 2);
      chk(trav_req, 0, "R4 idle, not sleeping");
      pulse_sof();
      chk(trav_req, 1, "R2 restart next sof");
      // R8 set and clear in the same cycle
      pulse_empty();
      pulse_tick(SLP - 1);
      recl_clr = 1; tick = 1; @(negedge clk); recl_clr = 0; tick = 0;
      chk(recl_stat, 1, "R8 set wins over clear");
      chk(trav_req, 1, "R6 wake with clear");
      // R9 disable during sleep clears timer
      pulse_empty();
      pulse_tick(2);
      sched_en = 0; @(negedge clk);
      chk(trav_req, 0, "R9 disable forces idle");
      sched_en = 1;
      pulse_sof();
      chk(trav_req, 1, "R9 restart after enable");
      pulse_empty();
      pulse_tick(SLP - 1);
      chk(trav_req, 0, "R9 full sleep after reload");
      pulse_tick(1);
      chk(trav_req, 1, "R9 wake after full sleep");
      sched_en = 0; @(negedge clk);
      chk(trav_req, 0, "R9 disable while traversing");
      sched_en = 1;
      // constrained random phase, checked by the model every cycle
      for (int i = 0; i < 4000; i++) begin
         sched_en   = ($urandom % 100) < 97;
         per_busy   = ($urandom % 100) < 20;
         sof        = ($urandom % 100) < 12;
         mf_end     = ($urandom % 100) < 4;
         list_empty = ($urandom % 100) < 10;
         tick       = ($urandom % 100) < 35;
         recl_clr   = ($urandom % 100) < 8;
         @(negedge clk);
      end
      sched_en = 0; per_busy = 0; sof = 0; mf_end = 0; list_empty = 0; tick = 0; recl_clr = 0;
      @(negedge clk);
      chk(trav_req, 0, "R9 final disable");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule